// File: doc/BRIEF.md
# Three-Phase Hall Commutator with Low-Side PWM Gate Sequencing

This block turns three digitised rotor-position sensor bits into six gate-enable signals for a three-phase bridge of N-channel switches. Each step of the six-step sequence names one leg whose high-side switch conducts for the whole step. It also names one leg whose low-side switch is chopped by an externally generated PWM on/off signal. While that low-side switch is chopped off, the high-side switch of the same leg is turned on, so the winding current freewheels through a conducting channel rather than a body diode. Every change of side on a leg passes through an interval of programmable length in which both switches of that leg are off.

Around the step decode sits a fixed order of overrides. A global all-off request has the highest priority, followed by the halt command, the short brake and the low-side-only protection cut. A cycle-by-cycle current-limit trip ends the present low-side pulse and holds it off until the PWM signal next rises. A system controller supplies the PWM signal, the trip comparator output and the protection flags. The block registers its outputs and drives the gate-driver stage directly.

Top module: `bldc_gate_sequencer`

## Requirements
- R1: With `reverse_i`=0 the sensor code `{hall_i[2],hall_i[1],hall_i[0]}` selects (high leg / low leg, legs U=bit0, V=bit1, W=bit2): 101→V/U, 100→W/U, 110→W/V, 010→U/V, 011→U/W, 001→V/W; in steady state with `pwm_on_i`=1 exactly those two enables are high.
- R2: With `reverse_i`=1 the pair is the one R1 gives for the bitwise complement of `hall_i`.
- R3: Sensor codes 000 and 111 drive all six enables low one cycle later.
- R4: With `pwm_on_i`=0 the low-leg enable is low and, after the dead interval, that leg's high-side enable is high; the step's high-leg enable stays high. A low-side enable is only ever high in the cycle after `pwm_on_i` was high.
- R5: When a leg changes between high side and low side, both of its enables are low for exactly `DEAD_CYC` consecutive cycles; a leg that has been off for at least `DEAD_CYC` cycles turns on in the cycle after the request.
- R6: `halt_i`=1 drives all six enables low in the next cycle.
- R7: `brake_i`=1 drives all low-side enables low in the next cycle and, after the dead interval, all three high-side enables high; a current-limit trip seen while braking is not remembered after the brake ends.
- R8: `ilim_trip_i`=1 drives all low-side enables low in the next cycle, and the low side stays off until the next rising edge of `pwm_on_i`, even if the trip drops earlier.
- R9: `lowside_off_i`=1 drives all low-side enables low in the next cycle, leaves the step's high-leg enable on, and suppresses freewheel high-side conduction.
- R10: `all_off_i`=1 drives all six enables low in the next cycle, overriding brake.
- R11: During reset all six enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall_i | input | 3 | Digitised rotor sensor bits, bit 2 = first sensor |
| reverse_i | input | 1 | 1 selects reverse rotation |
| halt_i | input | 1 | 1 = stop, all switches off |
| brake_i | input | 1 | 1 = short brake through the high side |
| pwm_on_i | input | 1 | PWM on-phase for the low-side switch |
| ilim_trip_i | input | 1 | Current-limit comparator trip |
| lowside_off_i | input | 1 | Protection request, low side off |
| all_off_i | input | 1 | Supply fault or initial reset, all off |
| gate_hi_o | output | 3 | High-side enables, bit0=U, bit1=V, bit2=W |
| gate_lo_o | output | 3 | Low-side enables, bit0=U, bit1=V, bit2=W |

## Verification
The hardest state to reach from the ports is a trip remembered across a period in which the trip input has already fallen while the PWM signal stays high. The bench holds `pwm_on_i` high, pulses the trip and releases it, then waits well beyond the dead interval and confirms the low side stays off. It then lowers and raises the PWM signal to show that the rising edge alone releases it. The same pulse sent during a brake, followed by releasing the brake with PWM still high, shows that braking discards the trip. The dead interval is measured by counting idle cycles on one leg while toggling the PWM signal in both directions.

// File: rtl/bgs_pkg.sv
package bgs_pkg;

   localparam int unsigned LEGS = 3;

   typedef enum logic [1:0] {
      LEG_OFF = 2'd0,
      LEG_HI  = 2'd1,
      LEG_LO  = 2'd2
   } leg_mode_e;

endpackage

// File: rtl/bgs_step_decode.sv
module bgs_step_decode
   import bgs_pkg::*;
(
   input  logic [LEGS-1:0] hall_i,
   input  logic            rev_i,
   output logic [LEGS-1:0] hi_sel_o,
   output logic [LEGS-1:0] lo_sel_o,
   output logic            valid_o
);

   logic [LEGS-1:0] code;

   // Reverse rotation reuses the forward table on the complemented code.
   assign code = rev_i ? ~hall_i : hall_i;

   always_comb begin
      hi_sel_o = '0;
      lo_sel_o = '0;
      unique case (code)
         3'b101: begin hi_sel_o = 3'b010; lo_sel_o = 3'b001; end
         3'b100: begin hi_sel_o = 3'b100; lo_sel_o = 3'b001; end
         3'b110: begin hi_sel_o = 3'b100; lo_sel_o = 3'b010; end
         3'b010: begin hi_sel_o = 3'b001; lo_sel_o = 3'b010; end
         3'b011: begin hi_sel_o = 3'b001; lo_sel_o = 3'b100; end
         3'b001: begin hi_sel_o = 3'b010; lo_sel_o = 3'b100; end
         default: begin hi_sel_o = '0; lo_sel_o = '0; end
      endcase
   end

   assign valid_o = |hi_sel_o;

   // R1: the two legs of a step are always distinct
   always_comb begin
      p_pair_disjoint_r1: assert ((hi_sel_o & lo_sel_o) == '0);
   end

endmodule

// File: rtl/bgs_trip_gate.sv
module bgs_trip_gate #(
   parameter bit LATCHED = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwm_on_i,
   input  logic trip_i,
   input  logic brake_i,
   output logic lo_allow_o
);

   generate
      if (LATCHED) begin : g_latched
         logic pwm_q;
         logic trip_q;
         logic pwm_rise;

         assign pwm_rise = pwm_on_i & ~pwm_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pwm_q  <= 1'b0;
               trip_q <= 1'b0;
            end else begin
               pwm_q <= pwm_on_i;
               if (brake_i)
                  trip_q <= 1'b0;
               else if (trip_i)
                  trip_q <= 1'b1;
               else if (pwm_rise)
                  trip_q <= 1'b0;
            end
         end

         // A new period starts clean even if the last one was tripped.
         assign lo_allow_o = pwm_on_i & ~trip_i & (~trip_q | pwm_rise);

         // R8: after a trip, low side stays blocked unless a new period begins
         p_trip_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (trip_i && !brake_i) |=> (!lo_allow_o || (pwm_on_i && !$past(pwm_on_i))));
      end else begin : g_pulse
         assign lo_allow_o = pwm_on_i & ~trip_i;
      end
   endgenerate

endmodule

// File: rtl/bgs_leg.sv
module bgs_leg
   import bgs_pkg::*;
#(
   parameter int unsigned DEAD_CYC = 500
) (
   input  logic      clk,
   input  logic      rst_n,
   input  leg_mode_e target_i,
   output logic      hi_o,
   output logic      lo_o
);

   localparam int unsigned CW = (DEAD_CYC < 2) ? 1 : $clog2(DEAD_CYC + 1);
   localparam logic [CW-1:0] CNT_LAST = CW'(DEAD_CYC - 1);
   localparam logic [CW-1:0] CNT_FULL = CW'(DEAD_CYC);

   generate
      if (DEAD_CYC < 1) begin : g_bad_dead
         $error("bgs_leg: DEAD_CYC must be at least 1");
      end
   endgenerate

   leg_mode_e     mode_q;
   logic [CW-1:0] cnt_q;

   // Turning off is immediate; turning on waits until the leg has been
   // idle for DEAD_CYC cycles (counter parks at CNT_LAST once expired).
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= LEG_OFF;
         cnt_q  <= CNT_LAST;
      end else if (target_i == mode_q) begin
         if (mode_q == LEG_OFF && cnt_q != CNT_LAST)
            cnt_q <= cnt_q + 1'b1;
      end else if (mode_q != LEG_OFF) begin
         mode_q <= LEG_OFF;
         cnt_q  <= '0;
      end else if (cnt_q == CNT_LAST) begin
         mode_q <= target_i;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign hi_o = (mode_q == LEG_HI);
   assign lo_o = (mode_q == LEG_LO);

   // Observation registers for the dead-interval checks below.
   logic [CW-1:0] off_run_q;
   logic          was_hi_q;
   logic          was_lo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_run_q <= '0;
         was_hi_q  <= 1'b0;
         was_lo_q  <= 1'b0;
      end else begin
         if (hi_o || lo_o)
            off_run_q <= '0;
         else if (off_run_q != CNT_FULL)
            off_run_q <= off_run_q + 1'b1;
         if (hi_o) begin
            was_hi_q <= 1'b1;
            was_lo_q <= 1'b0;
         end else if (lo_o) begin
            was_hi_q <= 1'b0;
            was_lo_q <= 1'b1;
         end
      end
   end

   // R5: side change on a leg is preceded by at least DEAD_CYC idle cycles
   p_dead_lo_to_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(hi_o) && was_lo_q) |-> (off_run_q >= CNT_FULL));
   p_dead_hi_to_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(lo_o) && was_hi_q) |-> (off_run_q >= CNT_FULL));
   p_no_direct_swap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hi_o) |-> $past(!lo_o));

endmodule

// File: rtl/bldc_gate_sequencer.sv
module bldc_gate_sequencer
   import bgs_pkg::*;
#(
   parameter int unsigned DEAD_CYC   = 500,
   parameter bit          TRIP_LATCH = 1'b1,
   parameter bit          SYNC_RECT  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] hall_i,
   input  logic       reverse_i,
   input  logic       halt_i,
   input  logic       brake_i,
   input  logic       pwm_on_i,
   input  logic       ilim_trip_i,
   input  logic       lowside_off_i,
   input  logic       all_off_i,
   output logic [2:0] gate_hi_o,
   output logic [2:0] gate_lo_o
);

   generate
      if (LEGS != 3) begin : g_bad_legs
         $error("bldc_gate_sequencer: three legs expected");
      end
   endgenerate

   logic [LEGS-1:0] hi_sel;
   logic [LEGS-1:0] lo_sel;
   logic            step_valid;
   logic            lo_allow;
   leg_mode_e       freewheel;
   leg_mode_e       target [LEGS];

   bgs_step_decode u_decode (
      .hall_i   (hall_i),
      .rev_i    (reverse_i),
      .hi_sel_o (hi_sel),
      .lo_sel_o (lo_sel),
      .valid_o  (step_valid)
   );

   bgs_trip_gate #(
      .LATCHED (TRIP_LATCH)
   ) u_trip (
      .clk        (clk),
      .rst_n      (rst_n),
      .pwm_on_i   (pwm_on_i),
      .trip_i     (ilim_trip_i),
      .brake_i    (brake_i),
      .lo_allow_o (lo_allow)
   );

   // What the chopped leg does while its low side is off.
   generate
      if (SYNC_RECT) begin : g_sync_rect
         assign freewheel = LEG_HI;
      end else begin : g_diode
         assign freewheel = LEG_OFF;
      end
   endgenerate

   generate
      for (genvar g = 0; g < LEGS; g++) begin : g_leg
         always_comb begin
            if (all_off_i || halt_i)
               target[g] = LEG_OFF;
            else if (brake_i)
               target[g] = LEG_HI;
            else if (!step_valid)
               target[g] = LEG_OFF;
            else if (hi_sel[g])
               target[g] = LEG_HI;
            else if (lo_sel[g] && !lowside_off_i)
               target[g] = lo_allow ? LEG_LO : freewheel;
            else
               target[g] = LEG_OFF;
         end

         bgs_leg #(
            .DEAD_CYC (DEAD_CYC)
         ) u_leg (
            .clk      (clk),
            .rst_n    (rst_n),
            .target_i (target[g]),
            .hi_o     (gate_hi_o[g]),
            .lo_o     (gate_lo_o[g])
         );
      end
   endgenerate

   // R6: halt clears every gate one cycle later
   p_halt_all_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      halt_i |=> (gate_hi_o == 3'b000 && gate_lo_o == 3'b000));
   // R10: global off request clears every gate one cycle later
   p_fault_all_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      all_off_i |=> (gate_hi_o == 3'b000 && gate_lo_o == 3'b000));
   // R9: protection cut removes low side one cycle later
   p_lowside_cut_r9: assert property (@(posedge clk) disable iff (!rst_n)
      lowside_off_i |=> (gate_lo_o == 3'b000));
   // R8: trip ends the low-side pulse one cycle later
   p_trip_cut_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ilim_trip_i |=> (gate_lo_o == 3'b000));
   // R7: braking never drives a low-side switch
   p_brake_no_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      brake_i |=> (gate_lo_o == 3'b000));
   // R3: invalid sensor codes give no drive
   p_invalid_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((hall_i == 3'b000 || hall_i == 3'b111) && !brake_i) |=>
      (gate_hi_o == 3'b000 && gate_lo_o == 3'b000));
   // R4: low side only follows a PWM on-phase, and only one leg at a time
   p_low_needs_pwm_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_lo_o != 3'b000) |-> $past(pwm_on_i));
   p_single_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gate_lo_o));

endmodule

// File: tb/bldc_gate_sequencer_tb.sv
module bldc_gate_sequencer_tb;

   localparam int unsigned DT     = 4;
   localparam int unsigned SETTLE = 2 * DT + 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] hall_i = 3'b000;
   logic       reverse_i = 1'b0;
   logic       halt_i = 1'b0;
   logic       brake_i = 1'b0;
   logic       pwm_on_i = 1'b0;
   logic       ilim_trip_i = 1'b0;
   logic       lowside_off_i = 1'b0;
   logic       all_off_i = 1'b0;
   logic [2:0] gate_hi_o;
   logic [2:0] gate_lo_o;

   int n_cmp = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   bldc_gate_sequencer #(
      .DEAD_CYC   (DT),
      .TRIP_LATCH (1'b1),
      .SYNC_RECT  (1'b1)
   ) u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .hall_i        (hall_i),
      .reverse_i     (reverse_i),
      .halt_i        (halt_i),
      .brake_i       (brake_i),
      .pwm_on_i      (pwm_on_i),
      .ilim_trip_i   (ilim_trip_i),
      .lowside_off_i (lowside_off_i),
      .all_off_i     (all_off_i),
      .gate_hi_o     (gate_hi_o),
      .gate_lo_o     (gate_lo_o)
   );

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [2:0] exp_hi, input logic [2:0] exp_lo);
      n_cmp++;
      if (gate_hi_o !== exp_hi || gate_lo_o !== exp_lo) begin
         n_bad++;
         $display("FAIL %s: hi=%b lo=%b expected hi=%b lo=%b", req, gate_hi_o, gate_lo_o, exp_hi, exp_lo);
      end
   endtask

   task automatic chk_int(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   // Steady-state expectation from the step table: returns {hi, lo}.
   function automatic logic [5:0] expect_steady(input logic [2:0] h, input logic rev, input logic pwm);
      logic [2:0] c;
      int hl, ll;
      logic [2:0] hi, lo;
      c = rev ? ~h : h;
      hl = -1; ll = -1;
      case (c)
         3'b101: begin hl = 1; ll = 0; end
         3'b100: begin hl = 2; ll = 0; end
         3'b110: begin hl = 2; ll = 1; end
         3'b010: begin hl = 0; ll = 1; end
         3'b011: begin hl = 0; ll = 2; end
         3'b001: begin hl = 1; ll = 2; end
         default: ;
      endcase
      if (hl < 0) return 6'b0;
      lo = pwm ? (3'b001 << ll) : 3'b000;
      hi = (3'b001 << hl) | (pwm ? 3'b000 : (3'b001 << ll));
      return {hi, lo};
   endfunction

   task automatic summary_and_end();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      summary_and_end();
   end

   initial begin
      logic [5:0] e;
      int n;
      step(3);
      chk("R11 reset", 3'b000, 3'b000);
      rst_n = 1'b1;
      step(SETTLE);

      // Sweep every direction, sensor code and PWM level (R1, R2, R3, R4)
      for (int d = 0; d < 2; d++) begin
         for (int h = 0; h < 8; h++) begin
            for (int p = 0; p < 2; p++) begin
               reverse_i = d[0];
               hall_i    = h[2:0];
               pwm_on_i  = p[0];
               step(SETTLE);
               e = expect_steady(h[2:0], d[0], p[0]);
               if (h == 0 || h == 7)
                  chk("R3 invalid code", e[5:3], e[2:0]);
               else if (p == 0)
                  chk("R4 freewheel", e[5:3], e[2:0]);
               else if (d == 1)
                  chk("R2 reverse", e[5:3], e[2:0]);
               else
                  chk("R1 forward", e[5:3], e[2:0]);
            end
         end
      end

      // R5: dead interval on leg U, low to high
      reverse_i = 1'b0; hall_i = 3'b101; pwm_on_i = 1'b1;
      step(SETTLE);
      pwm_on_i = 1'b0;
      step(1);
      n = 0;
      for (int k = 0; k < 50; k++) begin
         if (gate_hi_o[0]) break;
         if (!gate_lo_o[0]) n++;
         step(1);
      end
      chk_int("R5 dead lo->hi", n, DT);
      // R5: dead interval on leg U, high to low
      pwm_on_i = 1'b1;
      step(1);
      n = 0;
      for (int k = 0; k < 50; k++) begin
         if (gate_lo_o[0]) break;
         if (!gate_hi_o[0]) n++;
         step(1);
      end
      chk_int("R5 dead hi->lo", n, DT);
      // R5: idle legs turn on in one cycle
      hall_i = 3'b000;
      step(SETTLE);
      hall_i = 3'b101;
      step(1);
      chk("R5 fast entry", 3'b010, 3'b001);

      // R6: halt
      halt_i = 1'b1;
      step(1);
      chk("R6 halt", 3'b000, 3'b000);
      halt_i = 1'b0;
      step(SETTLE);
      chk("R6 resume", 3'b010, 3'b001);

      // R7: brake, and trip forgotten after brake
      brake_i = 1'b1;
      step(1);
      n_cmp++;
      if (gate_lo_o !== 3'b000) begin
         n_bad++;
         $display("FAIL R7 brake low cut: lo=%b expected lo=000", gate_lo_o);
      end
      step(SETTLE);
      chk("R7 brake steady", 3'b111, 3'b000);
      ilim_trip_i = 1'b1;
      step(1);
      ilim_trip_i = 1'b0;
      step(2);
      brake_i = 1'b0;
      step(SETTLE);
      chk("R7 trip ignored in brake", 3'b010, 3'b001);

      // R8: latched current-limit trip
      ilim_trip_i = 1'b1;
      step(1);
      chk("R8 trip cut", 3'b010, 3'b000);
      ilim_trip_i = 1'b0;
      step(SETTLE);
      chk("R8 trip held", 3'b011, 3'b000);
      pwm_on_i = 1'b0;
      step(SETTLE);
      pwm_on_i = 1'b1;
      step(SETTLE);
      chk("R8 released by new period", 3'b010, 3'b001);

      // R9: low-side protection cut
      lowside_off_i = 1'b1;
      step(1);
      chk("R9 low cut", 3'b010, 3'b000);
      step(SETTLE);
      chk("R9 no freewheel", 3'b010, 3'b000);
      lowside_off_i = 1'b0;
      step(SETTLE);

      // R10: global off beats brake
      brake_i   = 1'b1;
      all_off_i = 1'b1;
      step(1);
      chk("R10 all off", 3'b000, 3'b000);
      step(SETTLE);
      chk("R10 all off held", 3'b000, 3'b000);
      all_off_i = 1'b0;
      brake_i   = 1'b0;
      step(SETTLE);
      chk("R10 recovery", 3'b010, 3'b001);

      summary_and_end();
   end

endmodule